// File: doc/BRIEF.md
# Segment Descriptor Loader

This block turns a 16-bit segment selector into a checked segment description. On a load request it decides whether the selector names the global descriptor table or the current local descriptor table. It catches the null selector and any selector whose slot lies past the table's limit without touching memory. Otherwise it issues two 32-bit reads for the 8-byte descriptor over a one-cycle request / later-response memory port. From the two words it reassembles the scattered 32-bit base and the 20-bit limit, and it scales the limit by the granularity bit. It returns the base, the effective limit, the attribute bits and a 2-bit fault code, all valid in the cycle of a one-cycle `done` pulse.

The block also holds the global table register, which is a 32-bit base and a 16-bit limit written directly. It also holds the local table register. Software sees only a selector in the local table register. Loading it runs the same fetch through the global table, and on success the fetched base and effective limit become the local table's window. Privilege comparison, paging and exception delivery belong to the surrounding pipeline.

Top module: `seg_desc_loader`

## Requirements
- R1: After reset `done`, `mem_req` and `busy` are 0 and `ltab_sel` is 0. The local table is unloaded.
- R2: Selector bit 2 picks the local table (1) or the global table (0), and bits 15..3 are the index. The block reads the low word at table base + index*8 and then the high word at that address + 4, each as a one-cycle `mem_req`.
- R3: `seg_base` is {high[31:24], high[7:0], low[31:16]}.
- R4: The raw limit is {high[19:16], low[15:0]}. When G (high bit 23) is 0, `seg_limit` is the raw limit zero-extended. When G is 1, `seg_limit` is {raw limit, 12'hFFF}.
- R5: `seg_attr` is {high[23:20], high[15:8]}, that is {G, D, reserved, AVL, P, DPL[1:0], S, TYPE[2:0], A}.
- R6: A selector whose bits 15..2 are all zero is null. A null selector makes no memory read and finishes with fault 3, with base, limit and attributes all zero. A selector with index 0 and bit 2 set is not null.
- R7: If index*8+7 exceeds the chosen table's limit, the block makes no memory read and finishes with fault 1, with base, limit and attributes all zero. While the local table is unloaded, every local selector gets fault 1.
- R8: When P (high bit 15) is 0, the fault is 2, and base, limit and attributes are still returned as decoded.
- R9: `done` is high for exactly one cycle. After a fetch it rises in the cycle after the second read response. `busy` is high from acceptance until `done`, and a request made while busy is ignored. Fault code values: 0 none, 1 table limit, 2 not present, 3 null.
- R10: A pulse on `gtab_wr` loads the global base and 16-bit limit, and later lookups use the new values.
- R11: A request with `req_ltab`=1 loads the local table register through the global table. If it gets fault 0, `ltab_sel` takes the selector and local lookups use the fetched base and effective limit. If it gets fault 3, the local table becomes unloaded and `ltab_sel` becomes 0. A selector with bit 2 set gets fault 1 with no read. Fault 1 or fault 2 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gtab_wr | input | 1 | Write the global table register |
| gtab_base_in | input | 32 | New global table base |
| gtab_limit_in | input | 16 | New global table limit |
| req_valid | input | 1 | Load request, accepted when not busy |
| req_ltab | input | 1 | 1: load the local table register, 0: segment load |
| req_sel | input | 16 | Selector to resolve |
| busy | output | 1 | A load is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| done | output | 1 | Result valid, one cycle |
| fault | output | 2 | Fault code |
| seg_base | output | 32 | Assembled segment base |
| seg_limit | output | 32 | Effective segment limit |
| seg_attr | output | 12 | Attribute bits |
| ltab_sel | output | 16 | Local table register selector |

## Verification
The bench loads descriptors whose base bytes and limit nibbles all differ. A swapped or shifted field therefore shows up in the base or limit, and descriptors with G set and clear separate the two limit scalings. Selectors at a table's last slot and one slot past it probe the limit comparison from both sides. The null selector, with and without low bits set, is run against local index 0 to separate the null check from index 0. Local-table loads that succeed, fault or are null are each followed by local lookups and a read of `ltab_sel`, which shows whether the register changed. Response latencies of one and several cycles, plus a request injected while busy, test the `done` timing and the rule that requests are ignored while busy.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

    localparam int AW      = 32;
    localparam int SELW    = 16;
    localparam int GLIMW   = 16;
    localparam int RAWLIMW = 20;
    localparam int PAGEW   = 12;
    localparam int ATTRW   = 12;
    localparam int SLOT_SH = 3;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_NOTP  = 2'd2,
        FLT_NULL  = 2'd3
    } fault_e;

    typedef struct packed {
        logic       gran;
        logic       opsz;
        logic       rsv;
        logic       avl;
        logic       present;
        logic [1:0] dpl;
        logic       seg_kind;
        logic [2:0] typ;
        logic       acc;
    } attr_t;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        attr_t         attr;
    } seg_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD0, ST_W0, ST_RD1, ST_W1, ST_FIN
    } st_e;

    // sel_hi is selector bits 15..2: [0] table bit, [13:1] index
    function automatic logic sel_is_null(input logic [SELW-3:0] sel_hi);
        return sel_hi == '0;
    endfunction

    function automatic logic [AW-1:0] slot_last_byte(input logic [SELW-4:0] idx);
        return {{(AW-SELW){1'b0}}, idx, {SLOT_SH{1'b1}}};
    endfunction

    function automatic logic [AW-1:0] slot_offset(input logic [SELW-4:0] idx);
        return {{(AW-SELW){1'b0}}, idx, {SLOT_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
    import seg_desc_pkg::*;
(
    input  logic [SELW-3:0]  sel_hi,
    input  logic             for_ltab,
    input  logic [AW-1:0]    gbase,
    input  logic [GLIMW-1:0] glimit,
    input  logic             lvalid,
    input  logic [AW-1:0]    lbase,
    input  logic [AW-1:0]    llimit,
    output logic [AW-1:0]    desc_addr,
    output logic             early_fault,
    output fault_e           early_code
);
    logic              use_local;
    logic [SELW-4:0]   idx;
    logic [AW-1:0]     last_b;
    logic [AW-1:0]     tbl_lim;

    assign idx       = sel_hi[SELW-3:1];
    assign use_local = sel_hi[0];
    assign last_b    = slot_last_byte(idx);
    assign tbl_lim   = use_local ? llimit : {{(AW-GLIMW){1'b0}}, glimit};
    assign desc_addr = (use_local ? lbase : gbase) + slot_offset(idx);

    always_comb begin
        early_fault = 1'b1;
        early_code  = FLT_LIMIT;
        if (for_ltab && use_local) begin
            early_code = FLT_LIMIT;
        end else if (sel_is_null(sel_hi)) begin
            early_code = FLT_NULL;
        end else if (use_local && !lvalid) begin
            early_code = FLT_LIMIT;
        end else if (last_b > tbl_lim) begin
            early_code = FLT_LIMIT;
        end else begin
            early_fault = 1'b0;
            early_code  = FLT_NONE;
        end
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_desc_pkg::*;
(
    input  logic [31:0] lo_word,
    input  logic [31:0] hi_word,
    output seg_t        seg
);
    logic [RAWLIMW-1:0] raw_lim;

    assign raw_lim = {hi_word[19:16], lo_word[15:0]};

    always_comb begin
        seg.base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        seg.attr  = attr_t'({hi_word[23:20], hi_word[15:8]});
        if (seg.attr.gran)
            seg.limit = {raw_lim, {PAGEW{1'b1}}};
        else
            seg.limit = {{(AW-RAWLIMW){1'b0}}, raw_lim};
    end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import seg_desc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             gtab_wr,
    input  logic [AW-1:0]    gtab_base_in,
    input  logic [GLIMW-1:0] gtab_limit_in,
    input  logic             req_valid,
    input  logic             req_ltab,
    input  logic [SELW-1:0]  req_sel,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             done,
    output logic [1:0]       fault,
    output logic [AW-1:0]    seg_base,
    output logic [AW-1:0]    seg_limit,
    output logic [ATTRW-1:0] seg_attr,
    output logic [SELW-1:0]  ltab_sel
);
    st_e              state;
    logic [SELW-1:0]  sel_q;
    logic             ltab_q;
    fault_e           flt_q;
    logic [31:0]      lo_q, hi_q;
    logic [AW-1:0]    addr_q;

    logic [AW-1:0]    gbase_q;
    logic [GLIMW-1:0] glim_q;
    logic             lvalid_q;
    logic [AW-1:0]    lbase_q, llim_q;

    logic [AW-1:0]    desc_addr;
    logic             early_fault;
    fault_e           early_code;
    seg_t             seg;

    seg_sel_check u_chk_sel (
        .sel_hi      (req_sel[SELW-1:2]),
        .for_ltab    (req_ltab),
        .gbase       (gbase_q),
        .glimit      (glim_q),
        .lvalid      (lvalid_q),
        .lbase       (lbase_q),
        .llimit      (llim_q),
        .desc_addr   (desc_addr),
        .early_fault (early_fault),
        .early_code  (early_code)
    );

    seg_desc_unpack u_unpack (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .seg     (seg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sel_q  <= '0;
            ltab_q <= 1'b0;
            flt_q  <= FLT_NONE;
            lo_q   <= '0;
            hi_q   <= '0;
            addr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    sel_q  <= req_sel;
                    ltab_q <= req_ltab;
                    lo_q   <= '0;
                    hi_q   <= '0;
                    addr_q <= desc_addr;
                    flt_q  <= early_code;
                    state  <= early_fault ? ST_FIN : ST_RD0;
                end
                ST_RD0: state <= ST_W0;
                ST_W0: if (mem_rvalid) begin
                    lo_q  <= mem_rdata;
                    state <= ST_RD1;
                end
                ST_RD1: state <= ST_W1;
                ST_W1: if (mem_rvalid) begin
                    hi_q  <= mem_rdata;
                    flt_q <= mem_rdata[15] ? FLT_NONE : FLT_NOTP;
                    state <= ST_FIN;
                end
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // table registers
    always_ff @(posedge clk) begin
        if (rst) begin
            gbase_q  <= '0;
            glim_q   <= '0;
            lvalid_q <= 1'b0;
            lbase_q  <= '0;
            llim_q   <= '0;
            ltab_sel <= '0;
        end else begin
            if (gtab_wr) begin
                gbase_q <= gtab_base_in;
                glim_q  <= gtab_limit_in;
            end
            if (state == ST_FIN && ltab_q) begin
                if (flt_q == FLT_NONE) begin
                    lvalid_q <= 1'b1;
                    lbase_q  <= seg.base;
                    llim_q   <= seg.limit;
                    ltab_sel <= sel_q;
                end else if (flt_q == FLT_NULL) begin
                    lvalid_q <= 1'b0;
                    ltab_sel <= '0;
                end
            end
        end
    end

    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_RD0) || (state == ST_RD1);
    assign mem_addr  = (state == ST_RD1) ? addr_q + AW'(4) : addr_q;
    assign done      = (state == ST_FIN);
    assign fault     = flt_q;
    assign seg_base  = seg.base;
    assign seg_limit = seg.limit;
    assign seg_attr  = seg.attr;
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk
    import seg_desc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic             done,
    input logic [1:0]       fault,
    input logic [AW-1:0]    seg_base,
    input logic [AW-1:0]    seg_limit,
    input logic [ATTRW-1:0] seg_attr
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !mem_req && !busy));

    a_r2_single_cycle_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_after_resp: assert property (@(posedge clk) disable iff (rst)
        (done && (fault == FLT_NONE || fault == FLT_NOTP)) |-> $past(mem_rvalid));

    a_r6_null_zero: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NULL) |-> (seg_base == '0 && seg_limit == '0 && seg_attr == '0));

    a_r7_limit_zero: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_LIMIT) |-> (seg_base == '0 && seg_limit == '0));

    a_r4_page_scaled: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE && seg_attr[ATTRW-1]) |-> (seg_limit[PAGEW-1:0] == '1));

    a_r8_present_flag: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE) |-> seg_attr[7]);
endmodule

bind seg_desc_loader seg_desc_loader_chk u_sva (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .fault      (fault),
    .seg_base   (seg_base),
    .seg_limit  (seg_limit),
    .seg_attr   (seg_attr)
);

// File: tb/sim_seg_desc_loader.sv
module sim_seg_desc_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gtab_wr = 1'b0;
    logic [31:0] gtab_base_in = '0;
    logic [15:0] gtab_limit_in = '0;
    logic        req_valid = 1'b0;
    logic        req_ltab = 1'b0;
    logic [15:0] req_sel = '0;
    logic        busy, mem_req, done;
    logic [31:0] mem_addr, seg_base, seg_limit;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault;
    logic [11:0] seg_attr;
    logic [15:0] ltab_sel;

    seg_desc_loader u0 (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic [1:0]  f;
        logic [31:0] base;
        logic [31:0] lim;
        logic [11:0] attr;
        string       tag;
    } exp_t;

    exp_t            exp_q[$];
    logic [31:0]     addr_log[$];
    bit [31:0]       mem[bit [31:0]];
    int              checks = 0;
    int              errors = 0;
    int              mem_lat = 1;
    logic            prev_rv = 1'b0;

    // bench model of table registers
    logic [31:0] m_gbase = '0;
    logic [15:0] m_glim = '0;
    bit          m_lvalid = 0;
    logic [31:0] m_lbase = '0, m_llim = '0;
    logic [15:0] m_lsel = '0;

    function automatic bit [31:0] rd(input bit [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic put_desc(input bit [31:0] a, input bit [31:0] b, input bit [19:0] l,
                            input bit g, input bit p, input bit s, input bit [2:0] typ);
        mem[a]     = {b[15:0], l[15:0]};
        mem[a + 4] = {b[31:24], g, 1'b1, 1'b0, 1'b1, l[19:16], p, 2'b10, s, typ, 1'b1, b[23:16]};
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // memory responder: sees the one-cycle request, answers after mem_lat edges
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                automatic bit [31:0] a = mem_addr;
                addr_log.push_back(a);
                repeat (mem_lat) @(posedge clk);
                #1; mem_rvalid = 1'b1; mem_rdata = rd(a);
                @(posedge clk);
                #1; mem_rvalid = 1'b0; mem_rdata = '0;
            end
        end
    end

    // monitor: pops expected item at each done
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected done", 32'd1, 32'd0);
            end else begin
                automatic exp_t e = exp_q.pop_front();
                chk(fault == e.f, e.tag, "fault", {30'd0, fault}, {30'd0, e.f});
                chk(seg_base == e.base, e.tag, "base", seg_base, e.base);
                chk(seg_limit == e.lim, e.tag, "limit", seg_limit, e.lim);
                chk(seg_attr == e.attr, e.tag, "attr", {20'd0, seg_attr}, {20'd0, e.attr});
                if (e.f == 2'd0 || e.f == 2'd2)
                    chk(prev_rv == 1'b1, "R9", "done one cycle after response", {31'd0, prev_rv}, 32'd1);
            end
        end
        prev_rv = mem_rvalid;
    end

    task automatic run_load(input bit lt, input logic [15:0] sel, input string tag,
                            input int lat, input bit inject);
        exp_t        e;
        logic [31:0] exp_addr[$];
        bit          loc;
        logic [31:0] tb, tl, last, a, lo, hi;
        logic [19:0] raw;
        loc = sel[2];
        e.tag = tag; e.base = '0; e.lim = '0; e.attr = '0;
        last = {16'd0, sel[15:3], 3'b111};
        tb = loc ? m_lbase : m_gbase;
        tl = loc ? m_llim : {16'd0, m_glim};
        if (lt && loc) e.f = 2'd1;
        else if (sel[15:2] == 14'd0) e.f = 2'd3;
        else if (loc && !m_lvalid) e.f = 2'd1;
        else if (last > tl) e.f = 2'd1;
        else begin
            a = tb + {16'd0, sel[15:3], 3'b000};
            exp_addr.push_back(a); exp_addr.push_back(a + 4);
            lo = rd(a); hi = rd(a + 4);
            raw = {hi[19:16], lo[15:0]};
            e.base = {hi[31:24], hi[7:0], lo[31:16]};
            e.lim  = hi[23] ? {raw, 12'hFFF} : {12'd0, raw};
            e.attr = {hi[23:20], hi[15:8]};
            e.f    = hi[15] ? 2'd0 : 2'd2;
        end
        if (lt) begin
            if (e.f == 2'd0) begin m_lvalid = 1; m_lbase = e.base; m_llim = e.lim; m_lsel = sel; end
            else if (e.f == 2'd3) begin m_lvalid = 0; m_lsel = '0; end
        end
        exp_q.push_back(e);
        addr_log.delete();
        mem_lat = lat;
        @(negedge clk);
        req_valid = 1'b1; req_ltab = lt; req_sel = sel;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", {31'd0, busy}, 32'd1);
        if (inject) begin
            req_valid = 1'b1; req_ltab = 1'b0; req_sel = 16'h0008;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done pulse width", {31'd0, done}, 32'd0);
        chk(addr_log.size() == exp_addr.size(), (e.f == 2'd3) ? "R6" : (e.f == 2'd1 ? "R7" : "R2"),
            "read count", addr_log.size(), exp_addr.size());
        if (addr_log.size() == exp_addr.size())
            foreach (exp_addr[i])
                chk(addr_log[i] == exp_addr[i], "R2", "read address", addr_log[i], exp_addr[i]);
        chk(ltab_sel == m_lsel, "R11", "ltab_sel", {16'd0, ltab_sel}, {16'd0, m_lsel});
    endtask

    task automatic write_gtab(input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        gtab_wr = 1'b1; gtab_base_in = b; gtab_limit_in = l;
        @(negedge clk);
        gtab_wr = 1'b0;
        m_gbase = b; m_glim = l;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && mem_req == 0 && busy == 0, "R1", "idle after reset", {29'd0, done, mem_req, busy}, 32'd0);
        chk(ltab_sel == 16'd0, "R1", "ltab_sel after reset", {16'd0, ltab_sel}, 32'd0);

        // global table descriptors
        put_desc(32'h1008, 32'h12345678, 20'hABCDE, 0, 1, 1, 3'b101); // idx1 byte granular
        put_desc(32'h1010, 32'hFF00A000, 20'h00003, 1, 1, 1, 3'b001); // idx2 page granular
        put_desc(32'h1018, 32'h0BADF00D, 20'h01234, 0, 0, 1, 3'b001); // idx3 not present
        put_desc(32'h1020, 32'h00008000, 20'h00017, 0, 1, 0, 3'b001); // idx4 local table
        put_desc(32'h1038, 32'hA1B2C3D4, 20'h5E6F7, 1, 1, 1, 3'b011); // idx7 last slot
        put_desc(32'h8000, 32'h44332211, 20'h00FFF, 0, 1, 1, 3'b001); // local idx0
        put_desc(32'h8010, 32'h99887766, 20'hFEDCB, 1, 1, 1, 3'b110); // local idx2
        put_desc(32'h2008, 32'h0F1E2D3C, 20'h13579, 0, 1, 1, 3'b001); // after rebase

        write_gtab(32'h0000_1000, 16'h003F);                    // R10
        run_load(0, 16'h0008, "R3", 1, 0);                     // R3 R4 R5
        run_load(0, 16'h0013, "R4", 3, 0);                     // R4 page scaled, RPL bits set
        run_load(0, 16'h0018, "R8", 2, 0);                     // R8 not present
        run_load(0, 16'h0038, "R7", 1, 0);                     // R7 last slot fits
        run_load(0, 16'h0040, "R7", 1, 0);                     // R7 one slot past
        run_load(0, 16'h0000, "R6", 1, 0);                     // R6 null
        run_load(0, 16'h0003, "R6", 1, 0);                     // R6 null with RPL
        run_load(0, 16'h000C, "R11", 1, 0);                    // local unloaded -> limit
        run_load(1, 16'h0020, "R11", 2, 0);                    // load local table
        run_load(0, 16'h0004, "R6", 1, 0);                     // local index 0 not null
        run_load(0, 16'h0014, "R2", 4, 0);                     // local last slot
        run_load(0, 16'h001C, "R7", 1, 0);                     // local past limit
        run_load(1, 16'h0024, "R11", 1, 0);                    // table bit set -> limit
        run_load(1, 16'h0018, "R11", 1, 0);                    // not present, unchanged
        run_load(0, 16'h0014, "R11", 1, 0);                    // local still usable
        run_load(0, 16'h0010, "R9", 5, 1);                     // request while busy ignored
        write_gtab(32'h0000_2000, 16'h000F);                   // R10 rebase
        run_load(0, 16'h0008, "R10", 1, 0);
        run_load(0, 16'h0010, "R10", 1, 0);                    // now past limit
        run_load(1, 16'h0000, "R11", 1, 0);                    // null clears local
        run_load(0, 16'h0004, "R11", 1, 0);                    // local now faults

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all results seen", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule